// File: doc/BRIEF.md
# Peripheral Reset and Clock Bring-Up Sequencer

This block takes a serial peripheral from a cold, unclocked state to a running state in one fixed order. A one-cycle start request makes it assert the peripheral's controller reset and core reset together. It then holds the clock divider in reset while it drives the divide ratio and enables the divided clock, and then lets the divider run.

From that point every wait is measured in divided-clock ticks, which arrive as single-cycle pulses on `tick_i`, and not in fast clock cycles. The sequencer waits for the divided clock and its crossing FIFO to settle. It then releases the controller reset and waits a stage. Next it releases the core reset and waits another stage. Last, it turns on the conditional functional clock and raises `done_o`.

The block has no datapath, so every pin is a plain level or pulse with no handshake. Start requests that arrive while a sequence is running are dropped. `done_o` stays high until the next start request, and that request restarts the whole sequence from the top.

Top module: `periph_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first start request, all six control outputs are 0 and `div_sel_o` is 0. A start request held high during reset is not acted on after reset ends. Ticks with no start request change nothing.
- R2: A start request seen in the idle or done state makes the next cycle show `ctl_rst_o`=1 and `core_rst_o`=1, with the divider reset, clock enable, conditional clock enable and `done_o` all 0. This state lasts exactly one cycle.
- R3: The next cycle asserts `div_rst_o` with both resets still held and `div_sel_o` equal to `DIV_RATIO` (3 by default). This state lasts exactly one cycle.
- R4: The next cycle raises `clk_en_o` while `div_rst_o` is still 1. This state lasts exactly one cycle.
- R5: The next cycle releases `div_rst_o`, keeps both resets and `clk_en_o` high, and holds for exactly `SETTLE_TICKS`+`MARGIN` ticks (21 by default).
- R6: Then `ctl_rst_o` falls while `core_rst_o` stays high, and this holds for exactly `STAGE_TICKS`+`MARGIN` ticks (11 by default). The core reset never falls before the controller reset.
- R7: Then `core_rst_o` falls for another `STAGE_TICKS`+`MARGIN` ticks (11), after which `csclk_en_o` and `done_o` rise together. The conditional clock is never on while either reset is held.
- R8: Wait states count only `tick_i` pulses seen in that state. Ticks during the one-cycle steps are ignored. A wait state is left on the clock edge that samples its final tick.
- R9: A start request while the sequence is in progress (any state other than idle and done) is ignored, and the sequence continues unchanged.
- R10: `done_o` and the done-state outputs hold for as long as no start request arrives. A start request in the done state restarts at the R2 step, with `done_o` low.
- R11: `div_sel_o` is 0 in idle and in the first reset step, and `DIV_RATIO` in every later state, including done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| start_i | input | 1 | Start request, sampled on each rising edge |
| tick_i | input | 1 | One-cycle pulse per divided-clock period |
| ctl_rst_o | output | 1 | Peripheral controller reset, active high |
| core_rst_o | output | 1 | Peripheral core reset, active high |
| div_rst_o | output | 1 | Clock divider reset, active high |
| div_sel_o | output | DIV_W | Divide ratio code driven to the divider |
| clk_en_o | output | 1 | Divided clock enable |
| csclk_en_o | output | 1 | Conditional functional clock enable |
| done_o | output | 1 | Bring-up complete; held until next start |

## Verification
Every state has its own output pattern, so a wrong state shows at the ports in the cycle that follows the faulty edge. It appears either as a pattern that is not allowed or as a step out of order. A wrong wait count takes longer to show and only shows when the wait ends: the exit comes a tick early or late, and that is visible on the cycle after the edge that sampled the last tick. The bench sweeps tick periods and phase offsets. For each wait it counts the ticks it drove, checks the order of the patterns, checks that each one-cycle step lasts one cycle, and checks that start requests while busy leave the order untouched.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ASRT   = 3'd1,
    S_DSEL   = 3'd2,
    S_CKEN   = 3'd3,
    S_SETTLE = 3'd4,
    S_WCTL   = 3'd5,
    S_WCORE  = 3'd6,
    S_DONE   = 3'd7
  } state_t;

  typedef struct packed {
    logic ctl_rst;
    logic core_rst;
    logic div_rst;
    logic clk_en;
    logic csclk_en;
    logic done;
  } ctl_vec_t;

  function automatic logic is_wait(state_t s);
    return (s == S_SETTLE) || (s == S_WCTL) || (s == S_WCORE);
  endfunction

  function automatic logic is_rest(state_t s);
    return (s == S_IDLE) || (s == S_DONE);
  endfunction

endpackage

// File: rtl/brg_tick_wait.sv
`timescale 1ns/1ps
module brg_tick_wait #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q;

  // final tick of the current window
  assign hit_o = en_i && (cnt_q == lim_i - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hit_o) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/brg_step_fsm.sv
`timescale 1ns/1ps
module brg_step_fsm
  import brg_pkg::*;
#(
  parameter int CW        = 5,
  parameter int SETTLE_LIM = 21,
  parameter int STAGE_LIM  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          hit_i,
  output state_t        st_o,
  output logic          wait_o,
  output logic [CW-1:0] lim_o
);

  state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE, S_DONE: if (start_i) st_d = S_ASRT;
      S_ASRT:         st_d = S_DSEL;
      S_DSEL:         st_d = S_CKEN;
      S_CKEN:         st_d = S_SETTLE;
      S_SETTLE:       if (hit_i) st_d = S_WCTL;
      S_WCTL:         if (hit_i) st_d = S_WCORE;
      S_WCORE:        if (hit_i) st_d = S_DONE;
      default:        st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign wait_o = is_wait(st_q);
  assign lim_o  = (st_q == S_SETTLE) ? CW'(SETTLE_LIM) : CW'(STAGE_LIM);

endmodule

// File: rtl/brg_out_decode.sv
`timescale 1ns/1ps
module brg_out_decode
  import brg_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int DIV_RATIO = 3
) (
  input  state_t           st_i,
  output ctl_vec_t         vec_o,
  output logic [DIV_W-1:0] div_sel_o
);

  always_comb begin
    vec_o = '0;
    unique case (st_i)
      S_IDLE:   vec_o = '0;
      S_ASRT:   begin vec_o.ctl_rst = 1'b1; vec_o.core_rst = 1'b1; end
      S_DSEL:   begin vec_o.ctl_rst = 1'b1; vec_o.core_rst = 1'b1;
                      vec_o.div_rst = 1'b1; end
      S_CKEN:   begin vec_o.ctl_rst = 1'b1; vec_o.core_rst = 1'b1;
                      vec_o.div_rst = 1'b1; vec_o.clk_en = 1'b1; end
      S_SETTLE: begin vec_o.ctl_rst = 1'b1; vec_o.core_rst = 1'b1;
                      vec_o.clk_en = 1'b1; end
      S_WCTL:   begin vec_o.core_rst = 1'b1; vec_o.clk_en = 1'b1; end
      S_WCORE:  vec_o.clk_en = 1'b1;
      S_DONE:   begin vec_o.clk_en = 1'b1; vec_o.csclk_en = 1'b1;
                      vec_o.done = 1'b1; end
      default:  vec_o = '0;
    endcase
  end

  // ratio is driven from the divider-select step onward
  assign div_sel_o = (st_i == S_IDLE || st_i == S_ASRT) ? '0 : DIV_W'(DIV_RATIO);

endmodule

// File: rtl/periph_bringup_seq.sv
`timescale 1ns/1ps
module periph_bringup_seq
  import brg_pkg::*;
#(
  parameter int DIV_W        = 3,
  parameter int DIV_RATIO    = 3,
  parameter int SETTLE_TICKS = 20,
  parameter int STAGE_TICKS  = 10,
  parameter int MARGIN       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             ctl_rst_o,
  output logic             core_rst_o,
  output logic             div_rst_o,
  output logic [DIV_W-1:0] div_sel_o,
  output logic             clk_en_o,
  output logic             csclk_en_o,
  output logic             done_o
);

  localparam int SETTLE_LIM = SETTLE_TICKS + MARGIN;
  localparam int STAGE_LIM  = STAGE_TICKS + MARGIN;
  localparam int MAX_LIM    = (SETTLE_LIM > STAGE_LIM) ? SETTLE_LIM : STAGE_LIM;
  localparam int CW         = $clog2(MAX_LIM + 1);

  state_t        st;
  logic          in_wait;
  logic          hit;
  logic [CW-1:0] lim;
  ctl_vec_t      vec;

  brg_step_fsm #(
    .CW(CW), .SETTLE_LIM(SETTLE_LIM), .STAGE_LIM(STAGE_LIM)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_i(hit),
    .st_o(st), .wait_o(in_wait), .lim_o(lim)
  );

  brg_tick_wait #(.CW(CW)) u_wait (
    .clk(clk), .rst_n(rst_n), .en_i(in_wait && tick_i),
    .lim_i(lim), .hit_o(hit)
  );

  brg_out_decode #(.DIV_W(DIV_W), .DIV_RATIO(DIV_RATIO)) u_dec (
    .st_i(st), .vec_o(vec), .div_sel_o(div_sel_o)
  );

  assign ctl_rst_o  = vec.ctl_rst;
  assign core_rst_o = vec.core_rst;
  assign div_rst_o  = vec.div_rst;
  assign clk_en_o   = vec.clk_en;
  assign csclk_en_o = vec.csclk_en;
  assign done_o     = vec.done;

endmodule

// File: rtl/brg_checker.sv
`timescale 1ns/1ps
module brg_checker
  import brg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start_i,
  input logic   tick_i,
  input logic   ctl_rst_o,
  input logic   core_rst_o,
  input logic   div_rst_o,
  input logic   clk_en_o,
  input logic   csclk_en_o,
  input logic   done_o,
  input state_t st
);

  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rest(st) && start_i) |=> (ctl_rst_o && core_rst_o && !done_o && !csclk_en_o)); // R2

  AST_CLKEN_UNDER_DIVRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> div_rst_o); // R4

  AST_CTL_BEFORE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> !ctl_rst_o); // R6

  AST_CSCLK_RESETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    csclk_en_o |-> (!ctl_rst_o && !core_rst_o && clk_en_o)); // R7

  AST_WAIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait(st) && !tick_i) |=> $stable(st)); // R8

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_rest(st) && start_i) |=> (st != S_ASRT)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R10

endmodule

bind periph_bringup_seq brg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
  .ctl_rst_o(ctl_rst_o), .core_rst_o(core_rst_o), .div_rst_o(div_rst_o),
  .clk_en_o(clk_en_o), .csclk_en_o(csclk_en_o), .done_o(done_o), .st(st)
);

// File: tb/tb_periph_bringup_seq.sv
`timescale 1ns/1ps
module tb_periph_bringup_seq;

  localparam int DIV_W = 3;
  localparam int RATIO = 3;
  localparam int SETTLE_EXP = 20 + 1;
  localparam int STAGE_EXP  = 10 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic ctl_rst_o, core_rst_o, div_rst_o, clk_en_o, csclk_en_o, done_o;
  logic [DIV_W-1:0] div_sel_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  periph_bringup_seq #(.DIV_W(DIV_W), .DIV_RATIO(RATIO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .ctl_rst_o(ctl_rst_o), .core_rst_o(core_rst_o), .div_rst_o(div_rst_o),
    .div_sel_o(div_sel_o), .clk_en_o(clk_en_o), .csclk_en_o(csclk_en_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // phase from output pattern {ctl,core,divrst,clken,csclk,done}
  function automatic int phase();
    case ({ctl_rst_o, core_rst_o, div_rst_o, clk_en_o, csclk_en_o, done_o})
      6'b000000: return 0;
      6'b110000: return 1;
      6'b111000: return 2;
      6'b111100: return 3;
      6'b110100: return 4;
      6'b010100: return 5;
      6'b000100: return 6;
      6'b000111: return 7;
      default:   return -1;
    endcase
  endfunction

  function automatic string req_of(input int p);
    case (p)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_seq(input int per, input int off, input bit glitch);
    int cyc[8];
    int tk[8];
    bit lt[8];
    int ph, prev, k, guard;
    bit fin, t;
    for (int i = 0; i < 8; i++) begin cyc[i] = 0; tk[i] = 0; lt[i] = 0; end
    @(negedge clk); start_i = 1'b1; tick_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    prev = 0; k = 0; guard = 0; fin = 0;
    while (!fin) begin
      ph = phase();
      if (ph != prev) begin
        chk(ph == prev + 1, req_of(prev + 1), ph, prev + 1);
        if (ph != prev + 1) begin fin = 1; break; end
        if (ph == 1) chk(done_o == 1'b0, "R10", done_o, 0);
        prev = ph;
      end
      chk(div_sel_o == ((ph <= 1) ? 0 : RATIO), "R11", div_sel_o, (ph <= 1) ? 0 : RATIO);
      if (ph == 7) begin
        fin = 1;
      end else begin
        t = ((k + off) % per) == 0;
        k++;
        tick_i = t;
        cyc[ph]++;
        if (t) tk[ph]++;
        lt[ph] = t;
        start_i = (glitch && ph == 5 && cyc[5] == 1) ? 1'b1 : 1'b0;
        @(negedge clk);
        guard++;
        if (guard > 5000) begin
          chk(1'b0, "R8", guard, 0);
          fin = 1;
        end
      end
    end
    tick_i = 1'b0;
    start_i = 1'b0;
    chk(cyc[1] == 1, "R2", cyc[1], 1);
    chk(cyc[2] == 1, "R3", cyc[2], 1);
    chk(cyc[3] == 1, "R4", cyc[3], 1);
    chk(tk[4] == SETTLE_EXP, "R5", tk[4], SETTLE_EXP);
    chk(tk[5] == STAGE_EXP, glitch ? "R9" : "R6", tk[5], STAGE_EXP);
    chk(tk[6] == STAGE_EXP, "R7", tk[6], STAGE_EXP);
    chk(lt[4] && lt[5] && lt[6], "R8", {lt[4], lt[5], lt[6]}, 7);
  endtask

  initial begin : main
    int miss;
    // R1: reset with start and ticks active
    rst_n = 1'b0; start_i = 1'b1; tick_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(phase() == 0 && div_sel_o == 0, "R1", phase(), 0);
    rst_n = 1'b1; start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(phase() == 0, "R1", phase(), 0);
    // ticks alone do nothing
    for (int i = 0; i < 30; i++) begin
      tick_i = i[0];
      @(negedge clk);
    end
    tick_i = 1'b0;
    chk(phase() == 0 && div_sel_o == 0, "R1", phase(), 0);

    // R1: reset in the middle of a run
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 12; i++) begin tick_i = 1'b1; @(negedge clk); end
    tick_i = 1'b0;
    rst_n = 1'b0; #1;
    chk(phase() == 0, "R1", phase(), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(phase() == 0, "R1", phase(), 0);

    // sweep tick period and phase
    for (int per = 1; per <= 4; per++) begin
      for (int off = 0; off < per; off++) begin
        run_seq(per, off, (off == 0));
        // R10: done holds with ticks running and no start
        miss = 0;
        for (int i = 0; i < 25; i++) begin
          tick_i = (i % 2 == 0);
          @(negedge clk);
          if (phase() != 7) miss++;
        end
        tick_i = 1'b0;
        chk(miss == 0, "R10", miss, 0);
      end
    end
    run_seq(7, 3, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule